// File: doc/BRIEF.md
# Reference-Counted Pad Power Sequencer

This block drives the isolation controls of a pad power domain that several clients share. There are three controls: a main clamp, an early clamp and a core-voltage-down flag. A control that is high means its domain side is isolated or powered down. Clients send single-cycle enable and disable requests, and the block keeps a count of the users it holds. The domain is released only when the first user arrives. It is isolated again only when the last user leaves. Every other request changes the count alone.

The release lowers the main clamp, then the early clamp, then core-voltage-down. The isolation raises the same three controls in the opposite order. Consecutive steps are one step delay apart, and a parameter sets that delay in clock cycles (nominally 100 microseconds' worth). While a sequence is running, incoming requests wait in one pending slot per request kind. A busy flag covers the whole sequence. An error pulse reports a disable when the count is zero, or an enable when the count is already at its maximum.

Top module: `pad_power_sequencer`

## Requirements
- R1: A synchronous reset sets clamp_main, clamp_early and vcore_down to 1, busy and err_pulse to 0, and the use count to zero.
- R2: An enable taken at a clock edge while the count is zero lowers clamp_main at that same edge. clamp_early falls STEP_CYCLES edges later, and vcore_down falls STEP_CYCLES edges after that. busy rises with clamp_main and falls with vcore_down.
- R3: An enable taken while the count is non-zero and below its maximum increments the count. It changes no output and does not raise busy.
- R4: A disable taken while the count is two or more decrements the count and changes no output.
- R5: A disable taken while the count is one raises vcore_down at that edge. clamp_early rises STEP_CYCLES edges later, and clamp_main rises STEP_CYCLES edges after that. busy covers the whole sequence.
- R6: A disable taken while the count is zero raises err_pulse for one cycle, on the edge after it is taken. The count and all outputs are left as they were.
- R7: ctrl_word carries vcore_down in bit 31, clamp_early in bit 30 and clamp_main in bit 29. Every other bit is 0.
- R8: A request that arrives while busy is high is held and then taken on the first edge at which busy is low. Several requests of one kind during a single sequence collapse into one.
- R9: When an enable and a disable are both ready on an idle edge, the enable is taken first and the disable is taken on the next edge.
- R10: An enable taken when the count is at its maximum (2^CNT_W-1) raises err_pulse and leaves the count at that maximum. From there, exactly that many disables are needed to start the power-down.
- R11: The interval between consecutive steps of either sequence equals the STEP_CYCLES parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| clamp_main | output | 1 | Main isolation clamp, 1 = clamped |
| clamp_early | output | 1 | Early isolation clamp, 1 = clamped |
| vcore_down | output | 1 | Core-voltage-down flag, 1 = down |
| ctrl_word | output | 32 | Controls packed at bits 31, 30 and 29 |
| busy | output | 1 | A sequence is running |
| err_pulse | output | 1 | One-cycle unbalanced or overflow request error |

## Verification
The bench fires a disable at count zero. A design that decremented there would wrap the count and then isolate the domain on some later request. It also fires enables and disables into a running sequence. A design without pending slots would drop those requests, and one that acted on them at once would cut the sequence short. The bench sends an enable and a disable on the same idle edge, which shows whether one of them is lost. It drives the count to saturation, where a wrapping counter would power the domain down early. Each step interval is timed against the parameter, which catches a step delay that is off by one.

// File: rtl/pad_pwr_pkg.sv
package pad_pwr_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_UP_A = 3'd1,
    SQ_UP_B = 3'd2,
    SQ_DN_A = 3'd3,
    SQ_DN_B = 3'd4
  } seq_state_t;

  localparam int STAT_VCORE_BIT = 31;
  localparam int STAT_EARLY_BIT = 30;
  localparam int STAT_MAIN_BIT  = 29;

  localparam int REQ_EN  = 0;
  localparam int REQ_DIS = 1;
  localparam int REQ_KINDS = 2;

endpackage

// File: rtl/pps_step_timer.sv
module pps_step_timer #(
  parameter int STEP_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int TW = (STEP_CYCLES < 2) ? 1 : $clog2(STEP_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(STEP_CYCLES - 1);

  logic [TW-1:0] tmr;

  assign done = run && (tmr == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) tmr <= '0;
    else                     tmr <= tmr + 1'b1;
  end

  assert_timer_in_range_R11: assert property (@(posedge clk) disable iff (rst)
    tmr <= LAST);

endmodule

// File: rtl/pps_use_counter.sv
module pps_use_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic cnt_zero,
  output logic cnt_one,
  output logic cnt_full
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  assign cnt_zero = (cnt == '0);
  assign cnt_one  = (cnt == CNT_W'(1));
  assign cnt_full = (cnt == FULL);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
    else if (dec) cnt <= cnt - 1'b1;
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    !(inc && cnt_full));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    !(dec && cnt_zero));
  assert_single_op_R9: assert property (@(posedge clk) disable iff (rst)
    !(inc && dec));

endmodule

// File: rtl/pps_req_slot.sv
module pps_req_slot (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic ready
);
  logic held;

  assign ready = req | held;

  always_ff @(posedge clk) begin
    if (rst) held <= 1'b0;
    else     held <= (held | req) & ~take;
  end

  assert_take_has_request_R8: assert property (@(posedge clk) disable iff (rst)
    take |-> ready);

endmodule

// File: rtl/pps_seq_ctrl.sv
module pps_seq_ctrl
  import pad_pwr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_ready,
  input  logic dis_ready,
  input  logic cnt_zero,
  input  logic cnt_one,
  input  logic cnt_full,
  input  logic step_done,
  output logic en_take,
  output logic dis_take,
  output logic inc,
  output logic dec,
  output logic timer_run,
  output logic clamp_main,
  output logic clamp_early,
  output logic vcore_down,
  output logic busy,
  output logic err_pulse
);
  seq_state_t state, state_d;
  logic idle, start_up, start_dn;

  assign idle      = (state == SQ_IDLE);
  assign en_take   = idle & en_ready;
  assign dis_take  = idle & dis_ready & ~en_ready;
  assign inc       = en_take & ~cnt_full;
  assign dec       = dis_take & ~cnt_zero;
  assign start_up  = inc & cnt_zero;
  assign start_dn  = dec & cnt_one;
  assign timer_run = ~idle;

  always_comb begin
    state_d = state;
    unique case (state)
      SQ_IDLE: begin
        if (start_up)      state_d = SQ_UP_A;
        else if (start_dn) state_d = SQ_DN_A;
      end
      SQ_UP_A: if (step_done) state_d = SQ_UP_B;
      SQ_UP_B: if (step_done) state_d = SQ_IDLE;
      SQ_DN_A: if (step_done) state_d = SQ_DN_B;
      SQ_DN_B: if (step_done) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      clamp_main  <= 1'b1;
      clamp_early <= 1'b1;
      vcore_down  <= 1'b1;
      busy        <= 1'b0;
      err_pulse   <= 1'b0;
    end else begin
      state     <= state_d;
      busy      <= (state_d != SQ_IDLE);
      err_pulse <= (en_take & cnt_full) | (dis_take & cnt_zero);
      if (start_up)                          clamp_main  <= 1'b0;
      if (state == SQ_UP_A && step_done)     clamp_early <= 1'b0;
      if (state == SQ_UP_B && step_done)     vcore_down  <= 1'b0;
      if (start_dn)                          vcore_down  <= 1'b1;
      if (state == SQ_DN_A && step_done)     clamp_early <= 1'b1;
      if (state == SQ_DN_B && step_done)     clamp_main  <= 1'b1;
    end
  end

  // Release order: vcore_down low implies both clamps low; early low implies main low.
  assert_order_vcore_R2: assert property (@(posedge clk) disable iff (rst)
    !vcore_down |-> !clamp_early);
  assert_order_early_R5: assert property (@(posedge clk) disable iff (rst)
    !clamp_early |-> !clamp_main);
  assert_main_fall_busy_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(clamp_main) |-> busy);
  assert_vcore_rise_busy_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(vcore_down) |-> busy);
  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable({clamp_main, clamp_early, vcore_down}));
  assert_err_no_change_R6: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && !busy) |-> $stable({clamp_main, clamp_early, vcore_down}));

endmodule

// File: rtl/pad_power_sequencer.sv
module pad_power_sequencer
  import pad_pwr_pkg::*;
#(
  parameter int STEP_CYCLES = 20000,
  parameter int CNT_W       = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en_req,
  input  logic        dis_req,
  output logic        clamp_main,
  output logic        clamp_early,
  output logic        vcore_down,
  output logic [31:0] ctrl_word,
  output logic        busy,
  output logic        err_pulse
);
  logic [REQ_KINDS-1:0] req_in, req_ready, req_take;
  logic cnt_zero, cnt_one, cnt_full;
  logic inc, dec, timer_run, step_done;

  assign req_in[REQ_EN]  = en_req;
  assign req_in[REQ_DIS] = dis_req;

  for (genvar k = 0; k < REQ_KINDS; k++) begin : g_slot
    pps_req_slot u_slot (
      .clk   (clk),
      .rst   (rst),
      .req   (req_in[k]),
      .take  (req_take[k]),
      .ready (req_ready[k])
    );
  end

  pps_use_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .inc      (inc),
    .dec      (dec),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one),
    .cnt_full (cnt_full)
  );

  pps_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (timer_run),
    .done (step_done)
  );

  pps_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .en_ready    (req_ready[REQ_EN]),
    .dis_ready   (req_ready[REQ_DIS]),
    .cnt_zero    (cnt_zero),
    .cnt_one     (cnt_one),
    .cnt_full    (cnt_full),
    .step_done   (step_done),
    .en_take     (req_take[REQ_EN]),
    .dis_take    (req_take[REQ_DIS]),
    .inc         (inc),
    .dec         (dec),
    .timer_run   (timer_run),
    .clamp_main  (clamp_main),
    .clamp_early (clamp_early),
    .vcore_down  (vcore_down),
    .busy        (busy),
    .err_pulse   (err_pulse)
  );

  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[STAT_VCORE_BIT] = vcore_down;
    ctrl_word[STAT_EARLY_BIT] = clamp_early;
    ctrl_word[STAT_MAIN_BIT]  = clamp_main;
  end

  assert_word_matches_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[28:0] == '0);

endmodule

// File: tb/pad_power_sequencer_tb.sv
module pad_power_sequencer_tb;
  localparam int STEP  = 6;
  localparam int CW    = 3;
  localparam int MAXC  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_req = 1'b0, dis_req = 1'b0;
  logic clamp_main, clamp_early, vcore_down, busy, err_pulse;
  logic [31:0] ctrl_word;

  int n_checks = 0;
  int n_fail = 0;
  int cyc_n = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pad_power_sequencer #(.STEP_CYCLES(STEP), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
    .clamp_main(clamp_main), .clamp_early(clamp_early), .vcore_down(vcore_down),
    .ctrl_word(ctrl_word), .busy(busy), .err_pulse(err_pulse)
  );

  // Reference model built from the requirements: 0 idle, 1/2 power-up, 3/4 power-down
  int m_st, m_t, m_cnt;
  bit m_enp, m_disp, m_main, m_early, m_vc, m_err;

  always @(posedge clk) begin
    bit en_e, dis_e;
    if (rst) begin
      m_st = 0; m_t = 0; m_cnt = 0; m_enp = 0; m_disp = 0;
      m_main = 1; m_early = 1; m_vc = 1; m_err = 0;
    end else begin
      m_err = 0;
      en_e  = en_req | m_enp;
      dis_e = dis_req | m_disp;
      if (m_st == 0) begin
        if (en_e) begin
          m_enp = 0; m_disp = dis_e;
          if (m_cnt == MAXC) m_err = 1;
          else begin
            if (m_cnt == 0) begin m_main = 0; m_st = 1; m_t = 0; end
            m_cnt++;
          end
        end else if (dis_e) begin
          m_disp = 0; m_enp = 0;
          if (m_cnt == 0) m_err = 1;
          else begin
            m_cnt--;
            if (m_cnt == 0) begin m_vc = 1; m_st = 3; m_t = 0; end
          end
        end
      end else begin
        m_enp = en_e; m_disp = dis_e;
        if (m_t == STEP - 1) begin
          m_t = 0;
          case (m_st)
            1: begin m_early = 0; m_st = 2; end
            2: begin m_vc = 0;    m_st = 0; end
            3: begin m_early = 1; m_st = 4; end
            default: begin m_main = 1; m_st = 0; end
          endcase
        end else m_t++;
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc_n, act, exp);
    end
  endtask

  int t_main = 0, t_early = 0;
  bit p_main = 1, p_early = 1, p_vc = 1;

  task automatic compare();
    check(cur_req, "clamp_main", clamp_main, m_main);
    check(cur_req, "clamp_early", clamp_early, m_early);
    check(cur_req, "vcore_down", vcore_down, m_vc);
    check(cur_req, "busy", busy, (m_st != 0));
    check(cur_req, "err_pulse", err_pulse, m_err);
    check("R7", "ctrl_word", ctrl_word, {m_vc, m_early, m_main, 29'b0});
    // R11: step spacing measured at the ports
    if (p_main && !clamp_main) t_main = cyc_n;
    if (p_early && !clamp_early) begin
      t_early = cyc_n;
      check("R11", "up step 1 gap", t_early - t_main, STEP);
    end
    if (p_vc && !vcore_down) check("R11", "up step 2 gap", cyc_n - t_early, STEP);
    if (!p_vc && vcore_down) t_main = cyc_n;
    if (!p_early && clamp_early) begin
      t_early = cyc_n;
      check("R11", "down step 1 gap", t_early - t_main, STEP);
    end
    if (!p_main && clamp_main) check("R11", "down step 2 gap", cyc_n - t_early, STEP);
    p_main = clamp_main; p_early = clamp_early; p_vc = vcore_down;
  endtask

  task automatic cyc(input bit en, input bit dis);
    en_req = en; dis_req = dis;
    @(posedge clk);
    cyc_n++;
    @(negedge clk);
    en_req = 0; dis_req = 0;
    compare();
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5417));
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    check("R1", "reset clamp_main", clamp_main, 1);
    check("R1", "reset clamp_early", clamp_early, 1);
    check("R1", "reset vcore_down", vcore_down, 1);
    check("R1", "reset busy", busy, 0);
    compare();

    cur_req = "R6"; cyc(0, 1); idle_n(2);
    check("R6", "outputs after unbalanced disable", {clamp_main, clamp_early, vcore_down}, 3'b111);

    cur_req = "R2"; cyc(1, 0); idle_n(2 * STEP + 2);
    check("R2", "powered up", {clamp_main, clamp_early, vcore_down}, 3'b000);

    cur_req = "R3"; cyc(1, 0); idle_n(2);
    check("R3", "no busy on second enable", busy, 0);
    cur_req = "R4"; cyc(0, 1); idle_n(2);
    cur_req = "R5"; cyc(0, 1); idle_n(2 * STEP + 2);
    check("R5", "powered down", {clamp_main, clamp_early, vcore_down}, 3'b111);

    cur_req = "R8";
    cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(0, 1); idle_n(2 * STEP + 3);
    cyc(0, 1); cyc(0, 1); idle_n(2 * STEP + 3);

    cur_req = "R9"; cyc(1, 1); idle_n(2 * STEP + 3);

    cur_req = "R10";
    for (int i = 0; i < MAXC + 2; i++) begin cyc(1, 0); idle_n(2 * STEP + 2); end
    for (int i = 0; i < MAXC; i++)     begin cyc(0, 1); idle_n(2 * STEP + 2); end
    check("R10", "down after max disables", {clamp_main, clamp_early, vcore_down}, 3'b111);

    cur_req = "R8";
    for (int i = 0; i < 4000; i++) cyc(($urandom % 8) == 0, ($urandom % 7) == 0);
    idle_n(2 * STEP + 4);

    finish_run();
  end
endmodule